// File: doc/BRIEF.md
# Serial-Bus Tuner Synthesizer Control Slave

This block is the two-wire serial-bus (I2C) target that sets up a tuning synthesizer. A bus master writes to it to set the 15-bit divider word, a 7-bit control word (pump current, three test bits, two ratio-select bits and a tuning-output disable) and four band-switch enables. The master can also read a status byte that reports a power-up flag, the lock indication, the automatic pump-switch flag and a 3-bit converter code. The analog parts that sense the address level and convert the AFC voltage sit outside the block. Their digital results arrive as inputs.

SCL and SDA pass through a two-flip-flop synchroniser running on the system clock. A falling SDA edge while SCL is high is a START. A rising SDA edge while SCL is high is a STOP. After an accepted write address, the leading bit of the first data byte selects its type. A 0 means a divider pair follows. A 1 means a control and band-switch pair follows. Each later byte takes the next slot in the chain, up to the fourth byte. Each register takes its new value at the SCL falling edge that ends the eighth bit of the byte that completes it. In a read, the status byte is sent again for as long as the master acknowledges. The block releases SDA after a missing acknowledge.

Top module: `synth_i2c_ctrl`

## Requirements
- R1: The block accepts an address byte whose upper five bits are 11000 and whose bits 2..1 equal either `addr_sel_i` or the fixed value 01. It acknowledges such an address by holding SDA low during the ninth clock. Any other address gets no acknowledge, and the bytes that follow it up to the next START leave every register unchanged.
- R2: If the first data byte has bit 7 = 0, its bits 6..0 become divider bits 14..8 and the next byte supplies bits 7..0. `freq_o` changes only when the second byte of the pair completes. A transfer that stops after the first byte leaves `freq_o` unchanged.
- R3: If the first data byte has bit 7 = 1, its bits 6..0 load the control word at once. Bit 6 is CP, bits 5..3 are the test bits, bit 2 is RSA, bit 1 is RSB and bit 0 is OS. The byte after it is the band-switch byte, and its bits 3..0 drive `band_o[3:0]`. A transfer of the control byte alone leaves `band_o` unchanged.
- R4: Within one write, the bytes advance through the slots without readdressing. The order is divider, divider, control, band when the first byte is a divider byte, and control, band, divider, divider when it is a control byte. Each byte after the fourth is acknowledged and has no effect.
- R5: After reset, `freq_o` is 0, `band_o` is 0, CP = 1, the test bits are 001, RSA = 0, RSB = 0, OS = 0, and SDA is not driven.
- R6: A read address (bit 0 = 1) gets a status byte, sent MSB first. From MSB to LSB it holds the power-up flag, `lock_i`, `acps_i`, 1, 1, then `adc_i[2]`, `adc_i[1]` and `adc_i[0]`.
- R7: When the master acknowledges a status byte, the block sends a fresh status byte. When the master does not acknowledge, the block leaves SDA released during that acknowledge clock and sends nothing more.
- R8: The power-up flag is 1 after reset. It becomes 0 when a read ends without a master acknowledge and stays 0 from then on.
- R9: Every data byte of an addressed write is acknowledged with SDA low during its ninth clock. SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 2 | Selectable address bits from the level sensor |
| lock_i | input | 1 | Loop lock indication for the status byte |
| acps_i | input | 1 | Automatic pump-switch flag for the status byte |
| adc_i | input | 3 | Converter code for the status byte |
| freq_o | output | 15 | Divider word |
| cp_o | output | 1 | Pump current select |
| test_o | output | 3 | Test bits |
| rsa_o | output | 1 | Ratio select A |
| rsb_o | output | 1 | Ratio select B |
| os_o | output | 1 | Tuning output disable |
| band_o | output | 4 | Band-switch enables |

## Verification
The assertions check on every cycle that the SDA drive changes only while the synchronised SCL is low. They also check that the divider, control and band registers change only two cycles after an SCL falling edge, which is the byte commit point, and that the power-up flag never returns to 1 once it has cleared. The bench scenarios cover the rest:

- address matching and rejection;
- the classification by leading bit;
- both slot orders and the ignored fifth byte;
- partial writes;
- the status byte contents, repeated reads and the release on a missing acknowledge.

// File: rtl/synth_i2c_pkg.sv
package synth_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } bus_st_t;

    typedef enum logic [2:0] {
        SL_FIRST,
        SL_DB1,
        SL_DB2,
        SL_CB,
        SL_BB,
        SL_DONE
    } slot_t;

    // bit order matches the control byte bits 6..0
    typedef struct packed {
        logic       cp;
        logic [2:0] test;
        logic       rsa;
        logic       rsb;
        logic       os;
    } ctrl_t;

    localparam logic [4:0] ADDR_FIXED = 5'b11000;
    localparam logic [1:0] ADDR_ALWAYS = 2'b01;

    function automatic logic addr_hit(input logic [7:0] b, input logic [1:0] sel);
        return (b[7:3] == ADDR_FIXED) && ((b[2:1] == sel) || (b[2:1] == ADDR_ALWAYS));
    endfunction

endpackage

// File: rtl/synth_i2c_sync.sv
module synth_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_i};
        s_d.scl_prev = s_q.scl_pipe[STAGES-1];
        s_d.sda_prev = s_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s_o    = s_q.scl_pipe[STAGES-1];
    assign sda_s_o    = s_q.sda_pipe[STAGES-1];
    assign scl_rise_o = scl_s_o & ~s_q.scl_prev;
    assign scl_fall_o = ~scl_s_o & s_q.scl_prev;
    assign start_o    = scl_s_o & s_q.scl_prev & s_q.sda_prev & ~sda_s_o;
    assign stop_o     = scl_s_o & s_q.scl_prev & ~s_q.sda_prev & sda_s_o;
endmodule

// File: rtl/synth_i2c_link.sv
module synth_i2c_link
    import synth_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [1:0] addr_sel_i,
    input  logic [7:0] status_i,
    output logic       sda_oe_o,
    output logic       seq_new_o,
    output logic       wr_stb_o,
    output logic [7:0] wr_byte_o,
    output logic       rd_end_o
);
    typedef struct packed {
        bus_st_t    st;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       done;
        logic       rw;
        logic       oe;
        logic       seq_new;
        logic       wr_stb;
        logic       rd_end;
    } link_t;

    link_t l_d, l_q;

    always_comb begin
        l_d         = l_q;
        l_d.seq_new = 1'b0;
        l_d.wr_stb  = 1'b0;
        l_d.rd_end  = 1'b0;
        if (start_i) begin
            l_d.st   = ST_ADDR;
            l_d.cnt  = '0;
            l_d.done = 1'b0;
            l_d.oe   = 1'b0;
        end else if (stop_i) begin
            l_d.st   = ST_IDLE;
            l_d.done = 1'b0;
            l_d.oe   = 1'b0;
        end else begin
            case (l_q.st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise_i && !l_q.done) begin
                        l_d.sh  = {l_q.sh[6:0], sda_s_i};
                        l_d.cnt = l_q.cnt + 3'd1;
                        if (l_q.cnt == 3'd7) l_d.done = 1'b1;
                    end else if (scl_fall_i && l_q.done) begin
                        l_d.done = 1'b0;
                        l_d.cnt  = '0;
                        if (l_q.st == ST_ADDR) begin
                            if (addr_hit(l_q.sh, addr_sel_i)) begin
                                l_d.oe      = 1'b1;
                                l_d.rw      = l_q.sh[0];
                                l_d.seq_new = ~l_q.sh[0];
                                l_d.st      = ST_AACK;
                            end else begin
                                l_d.st = ST_IDLE;
                            end
                        end else begin
                            l_d.oe     = 1'b1;
                            l_d.wr_stb = 1'b1;
                            l_d.st     = ST_WACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        if (l_q.rw) begin
                            l_d.sh  = status_i;
                            l_d.oe  = ~status_i[7];
                            l_d.cnt = '0;
                            l_d.st  = ST_RDATA;
                        end else begin
                            l_d.oe = 1'b0;
                            l_d.st = ST_WDATA;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall_i) begin
                        l_d.oe = 1'b0;
                        l_d.st = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall_i) begin
                        if (l_q.cnt == 3'd7) begin
                            l_d.oe = 1'b0;
                            l_d.st = ST_RACK;
                        end else begin
                            l_d.sh  = {l_q.sh[6:0], 1'b0};
                            l_d.oe  = ~l_q.sh[6];
                            l_d.cnt = l_q.cnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        if (sda_s_i) begin
                            l_d.rd_end = 1'b1;
                            l_d.st     = ST_IDLE;
                        end else begin
                            l_d.done = 1'b1;
                        end
                    end else if (scl_fall_i && l_q.done) begin
                        l_d.done = 1'b0;
                        l_d.sh   = status_i;
                        l_d.oe   = ~status_i[7];
                        l_d.cnt  = '0;
                        l_d.st   = ST_RDATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q    <= '0;
            l_q.st <= ST_IDLE;
        end else begin
            l_q <= l_d;
        end
    end

    assign sda_oe_o  = l_q.oe;
    assign seq_new_o = l_q.seq_new;
    assign wr_stb_o  = l_q.wr_stb;
    assign wr_byte_o = l_q.sh;
    assign rd_end_o  = l_q.rd_end;
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
    import synth_i2c_pkg::*;
#(
    parameter int          FREQ_W     = 15,
    parameter int          BAND_W     = 4,
    parameter logic [6:0]  CTRL_RESET = 7'b1001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_new_i,
    input  logic              wr_stb_i,
    input  logic [7:0]        wr_byte_i,
    input  logic              rd_end_i,
    output logic [FREQ_W-1:0] freq_o,
    output ctrl_t             ctrl_o,
    output logic [BAND_W-1:0] band_o,
    output logic              por_o
);
    localparam int HI_W = FREQ_W - 8;

    typedef struct packed {
        slot_t             slot;
        logic              div_first;
        logic [HI_W-1:0]   hi;
        logic [FREQ_W-1:0] freq;
        ctrl_t             ctrl;
        logic [BAND_W-1:0] band;
        logic              por;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (seq_new_i) begin
            b_d.slot = SL_FIRST;
        end else if (wr_stb_i) begin
            case (b_q.slot)
                SL_FIRST: begin
                    if (wr_byte_i[7]) begin
                        b_d.ctrl      = ctrl_t'(wr_byte_i[6:0]);
                        b_d.div_first = 1'b0;
                        b_d.slot      = SL_BB;
                    end else begin
                        b_d.hi        = wr_byte_i[HI_W-1:0];
                        b_d.div_first = 1'b1;
                        b_d.slot      = SL_DB2;
                    end
                end
                SL_DB1: begin
                    b_d.hi   = wr_byte_i[HI_W-1:0];
                    b_d.slot = SL_DB2;
                end
                SL_DB2: begin
                    b_d.freq = {b_q.hi, wr_byte_i};
                    b_d.slot = b_q.div_first ? SL_CB : SL_DONE;
                end
                SL_CB: begin
                    b_d.ctrl = ctrl_t'(wr_byte_i[6:0]);
                    b_d.slot = SL_BB;
                end
                SL_BB: begin
                    b_d.band = wr_byte_i[BAND_W-1:0];
                    b_d.slot = b_q.div_first ? SL_DONE : SL_DB1;
                end
                default: ;
            endcase
        end
        if (rd_end_i) b_d.por = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q      <= '0;
            b_q.slot <= SL_DONE;
            b_q.ctrl <= ctrl_t'(CTRL_RESET);
            b_q.por  <= 1'b1;
        end else begin
            b_q <= b_d;
        end
    end

    assign freq_o = b_q.freq;
    assign ctrl_o = b_q.ctrl;
    assign band_o = b_q.band;
    assign por_o  = b_q.por;
endmodule

// File: rtl/synth_i2c_ctrl.sv
module synth_i2c_ctrl
    import synth_i2c_pkg::*;
#(
    parameter int FREQ_W      = 15,
    parameter int BAND_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        addr_sel_i,
    input  logic              lock_i,
    input  logic              acps_i,
    input  logic [2:0]        adc_i,
    output logic [FREQ_W-1:0] freq_o,
    output logic              cp_o,
    output logic [2:0]        test_o,
    output logic              rsa_o,
    output logic              rsb_o,
    output logic              os_o,
    output logic [BAND_W-1:0] band_o
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic       seq_new, wr_stb, rd_end, por_w;
    logic [7:0] wr_byte, status_w;
    ctrl_t      ctrl_w;

    assign status_w = {por_w, lock_i, acps_i, 2'b11, adc_i};

    synth_i2c_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_ev), .stop_o(stop_ev)
    );

    synth_i2c_link link_i (
        .clk(clk), .rst_n(rst_n), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall), .start_i(start_ev), .stop_i(stop_ev),
        .addr_sel_i(addr_sel_i), .status_i(status_w), .sda_oe_o(sda_oe_o),
        .seq_new_o(seq_new), .wr_stb_o(wr_stb), .wr_byte_o(wr_byte),
        .rd_end_o(rd_end)
    );

    synth_reg_bank #(.FREQ_W(FREQ_W), .BAND_W(BAND_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .seq_new_i(seq_new), .wr_stb_i(wr_stb),
        .wr_byte_i(wr_byte), .rd_end_i(rd_end), .freq_o(freq_o),
        .ctrl_o(ctrl_w), .band_o(band_o), .por_o(por_w)
    );

    assign cp_o   = ctrl_w.cp;
    assign test_o = ctrl_w.test;
    assign rsa_o  = ctrl_w.rsa;
    assign rsb_o  = ctrl_w.rsb;
    assign os_o   = ctrl_w.os;
endmodule

// File: rtl/synth_i2c_ctrl_chk.sv
module synth_i2c_ctrl_chk #(
    parameter int FREQ_W = 15,
    parameter int BAND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              scl_fall,
    input logic              sda_oe,
    input logic [FREQ_W-1:0] freq,
    input logic [6:0]        ctrl,
    input logic [BAND_W-1:0] band,
    input logic              por
);
    // R9: the data line drive moves only while SCL is low
    a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R2: the divider word changes only at a byte commit point
    a_r2_freq_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq) |-> $past(scl_fall, 2));

    // R3: the control word changes only at a byte commit point
    a_r3_ctrl_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> $past(scl_fall, 2));

    // R4: the band enables change only at a byte commit point
    a_r4_band_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band) |-> $past(scl_fall, 2));

    // R8: the power-up flag never returns once cleared
    a_r8_por_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !por |=> !por);
endmodule

bind synth_i2c_ctrl synth_i2c_ctrl_chk #(.FREQ_W(FREQ_W), .BAND_W(BAND_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
    .sda_oe(sda_oe_o), .freq(freq_o), .ctrl(ctrl_w), .band(band_o), .por(por_w)
);

// File: tb/synth_i2c_ctrl_tb_top.sv
module synth_i2c_ctrl_tb_top;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'b10;
    logic        lock = 1'b0;
    logic        acps = 1'b1;
    logic [2:0]  adc = 3'b000;
    logic        sda_oe;
    logic [14:0] freq;
    logic        cp, rsa, rsb, os;
    logic [2:0]  test;
    logic [3:0]  band;
    wire         sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    synth_i2c_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .lock_i(lock),
        .acps_i(acps), .adc_i(adc), .freq_o(freq), .cp_o(cp),
        .test_o(test), .rsa_o(rsa), .rsb_o(rsb), .os_o(os), .band_o(band)
    );

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    string       tag_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];

    task automatic expect_item(input string tag, input logic [31:0] v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    task automatic produce(input logic [31:0] v);
        act_q.push_back(v);
    endtask

    // monitor: compares results as they appear
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                string       t;
                logic [31:0] e, a;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s actual %h expected %h", t, a, e);
                end
            end
        end
    end

    function automatic logic [31:0] snap();
        return {6'd0, freq, cp, test, rsa, rsb, os, band};
    endfunction

    function automatic logic [31:0] regs(input logic [14:0] f, input logic [6:0] c,
                                         input logic [3:0] b);
        return {6'd0, f, c, b};
    endfunction

    task automatic qtr();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; qtr();
        sda_m = 1'b0; qtr();
        scl_m = 1'b0; qtr();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qtr();
        scl_m = 1'b1; qtr();
        sda_m = 1'b1; qtr();
    endtask

    task automatic bit_io(input logic b, output logic rb);
        sda_m = b; qtr();
        scl_m = 1'b1; qtr();
        rb = sda_line; qtr();
        scl_m = 1'b0; qtr();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic dummy;
        for (int i = 7; i >= 0; i--) bit_io(b[i], dummy);
        bit_io(1'b1, ack);
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d, output logic line);
        for (int i = 7; i >= 0; i--) bit_io(1'b1, d[i]);
        bit_io(!mack, line);
    endtask

    task automatic wr_checked(input string tag, input logic [7:0] b, input logic exp_ack);
        logic ack;
        expect_item(tag, {31'd0, exp_ack});
        wr_byte(b, ack);
        produce({31'd0, ack});
    endtask

    logic       done_flag = 1'b0;

    initial begin
        logic [7:0] d;
        logic       line;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5 reset state
        expect_item("R5 reset registers", regs(15'h0, 7'b1001000, 4'h0));
        produce(snap());
        expect_item("R5 sda released", 32'd0);
        produce({31'd0, sda_oe});

        // R1 fixed address, R4 divider-first order, R9 data acks
        bus_start();
        wr_checked("R1 ack fixed address", 8'hC2, 1'b0);
        wr_checked("R9 ack byte1", 8'h06, 1'b0);
        wr_checked("R9 ack byte2", 8'h40, 1'b0);
        wr_checked("R9 ack byte3", 8'hCE, 1'b0);
        wr_checked("R9 ack byte4", 8'h08, 1'b0);
        bus_stop();
        expect_item("R4 divider-first full write", regs(15'h0640, 7'b1001110, 4'h8));
        produce(snap());

        // R1 selected address, R4 control-first order and ignored fifth byte
        bus_start();
        wr_checked("R1 ack selected address", 8'hC4, 1'b0);
        wr_checked("R3 ack control first", 8'h83, 1'b0);
        wr_checked("R3 ack band", 8'h05, 1'b0);
        wr_checked("R4 ack div1", 8'h12, 1'b0);
        wr_checked("R4 ack div2", 8'h34, 1'b0);
        wr_checked("R4 ack fifth byte", 8'hFF, 1'b0);
        bus_stop();
        expect_item("R4 control-first write, fifth ignored", regs(15'h1234, 7'b0000011, 4'h5));
        produce(snap());

        // R1 mismatching address
        bus_start();
        wr_checked("R1 no ack foreign address", 8'hC6, 1'b1);
        wr_checked("R1 no ack after foreign", 8'h00, 1'b1);
        wr_checked("R1 no ack after foreign 2", 8'h00, 1'b1);
        bus_stop();
        expect_item("R1 foreign address no effect", regs(15'h1234, 7'b0000011, 4'h5));
        produce(snap());

        // R2 divider byte alone
        bus_start();
        wr_checked("R2 ack address", 8'hC2, 1'b0);
        wr_checked("R2 ack lone div1", 8'h7F, 1'b0);
        bus_stop();
        expect_item("R2 lone div1 no effect", regs(15'h1234, 7'b0000011, 4'h5));
        produce(snap());

        // R2 divider pair with max value
        bus_start();
        wr_checked("R2 ack address b", 8'hC2, 1'b0);
        wr_checked("R2 ack div1 max", 8'h7F, 1'b0);
        wr_checked("R2 ack div2 max", 8'hFF, 1'b0);
        bus_stop();
        expect_item("R2 divider pair", regs(15'h7FFF, 7'b0000011, 4'h5));
        produce(snap());

        // R3 control byte alone
        bus_start();
        wr_checked("R3 ack address", 8'hC4, 1'b0);
        wr_checked("R3 ack lone control", 8'hC8, 1'b0);
        bus_stop();
        expect_item("R3 control alone, band kept", regs(15'h7FFF, 7'b1001000, 4'h5));
        produce(snap());

        // R6 R7 R8 read
        lock = 1'b1; acps = 1'b0; adc = 3'b011;
        bus_start();
        wr_checked("R1 ack read address", 8'hC3, 1'b0);
        rd_byte(1'b1, d, line);
        expect_item("R6 status byte first", 32'h000000DB);
        produce({24'd0, d});
        rd_byte(1'b0, d, line);
        expect_item("R7 status byte repeated", 32'h000000DB);
        produce({24'd0, d});
        expect_item("R7 sda released on master nack", 32'd1);
        produce({31'd0, line});
        bus_stop();

        lock = 1'b0; acps = 1'b1; adc = 3'b100;
        bus_start();
        wr_checked("R1 ack read address selected", 8'hC5, 1'b0);
        rd_byte(1'b0, d, line);
        expect_item("R8 power flag cleared", 32'h0000003C);
        produce({24'd0, d});
        bus_stop();
        expect_item("R7 line idle after read", 32'd0);
        produce({31'd0, sda_oe});

        repeat (20) @(negedge clk);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule